// File: doc/BRIEF.md
# Descriptor-Table DMA Walker

This block moves one local buffer's worth of bytes between a device-side buffer and system memory. It finds the memory regions by walking a table of physical region descriptors that software has placed in memory. It fetches one 8-byte descriptor at a time over a read port. For each fetched region it issues transfer chunks on a separate payload port. Each chunk carries a memory address, a byte length, a direction and the local buffer index that the chunk starts at. The payload port does the actual data movement.

A host first loads the table base with `restart`. It then pulses `start` with a byte count and a direction. `busy` stays high while the walk runs. When the walk finishes, `done` pulses for one cycle. One of two sticky result flags then tells the host either that the whole buffer moved, or that the table ran out while bytes were still left. Both handshakes may stall for any number of cycles.

Top module: `prd_dma_engine`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, both result flags, `desc_rd_valid` and `xfer_valid` are low, and the table base and fetch pointer are zero.
- R2: A descriptor is the 64-bit little-endian value on `desc_rd_data`. Bits 31:0 give the region address. Bits 47:32 give the length, with bit 32 forced to zero. Bit 63 flags the final descriptor. Bits 62:48 are ignored.
- R3: A length field that becomes zero after the forcing gives a region of 65536 bytes. This covers raw values 0x0000 and 0x0001.
- R4: Every accepted fetch advances the fetch pointer by 8. `restart`, sampled while idle, loads both the table base and the fetch pointer from `tbl_base`.
- R5: Each chunk length is the smaller of the bytes left in the buffer and the bytes left in the region, and is never zero. After the chunk is accepted, the region address and the buffer index both advance by that length.
- R6: When a region is used up and it came from a descriptor with the final flag, the walk ends with `res_tbl_end` if buffer bytes remain.
- R7: When a region is used up and the fetch pointer is 4096 or more bytes past the table base, the walk ends with `res_tbl_end` and no further fetch is made.
- R8: The walk ends with `res_buf_done` as soon as the buffer is drained. This check comes before any table check. A zero-byte buffer finishes without any fetch.
- R9: `start`, sampled while idle, discards any leftover region, so the next chunk always comes from a freshly fetched descriptor. `start` alone does not reload the fetch pointer.
- R10: `xfer_write` equals the `dir_to_mem` value captured at `start` (1 means buffer to memory, 0 means memory to buffer).
- R11: While a request waits for its ready signal, the request's valid, address and length hold steady.
- R12: `done` is a one-cycle pulse that is never high together with `busy`. At most one result flag is set. The flags hold until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (idle only) |
| restart | input | 1 | Load table base and fetch pointer (idle only) |
| dir_to_mem | input | 1 | Direction for the walk being started |
| tbl_base | input | 32 | Table base address |
| buf_size | input | BUF_W | Local buffer byte count |
| desc_rd_valid | output | 1 | Descriptor read request |
| desc_rd_addr | output | 32 | Descriptor address |
| desc_rd_ready | input | 1 | Request accepted, data valid |
| desc_rd_data | input | 64 | Descriptor contents |
| xfer_valid | output | 1 | Chunk request |
| xfer_write | output | 1 | Chunk direction |
| xfer_addr | output | 32 | Chunk memory address |
| xfer_len | output | 17 | Chunk byte count |
| xfer_buf_idx | output | BUF_W | Chunk start index in local buffer |
| xfer_ready | input | 1 | Chunk done |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished pulse |
| res_buf_done | output | 1 | Result: buffer drained |
| res_tbl_end | output | 1 | Result: table ended first |

## Verification
The bench builds the block with its defaults: an 18-bit buffer count and a 4096-byte page guard. The 18-bit count allows a buffer larger than one 65536-byte region, so the bench can chain a zero-length descriptor into a second region. The 4096-byte guard is reached with 512 two-byte descriptors that never set the final flag, which keeps that run to a few thousand cycles. Stalls on both ports, odd raw lengths and a zero-byte buffer are driven directly.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;
  localparam int PRD_ADDR_W = 32;
  localparam int PRD_LEN_W  = 17;   // up to 65536
  localparam int PRD_BYTES  = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_FETCH = 2'd2,
    ST_MOVE  = 2'd3
  } walk_state_t;

  typedef struct packed {
    logic [PRD_ADDR_W-1:0] addr;
    logic [PRD_LEN_W-1:0]  len;
    logic                  last;
  } region_t;
endpackage

// File: rtl/prd_desc_decode.sv
module prd_desc_decode
  import prd_dma_pkg::*;
(
  input  logic [63:0] raw,
  output region_t     region
);
  logic [15:0] even_len;
  logic        unused_flags;

  assign even_len     = {raw[47:33], 1'b0};
  assign unused_flags = ^raw[62:48];

  always_comb begin
    region.addr = raw[31:0];
    region.last = raw[63];
    if (even_len == 16'd0) region.len = PRD_LEN_W'(17'h10000);
    else                   region.len = PRD_LEN_W'(even_len);
  end
endmodule

// File: rtl/prd_chunk_sizer.sv
module prd_chunk_sizer #(
  parameter int BUF_W = 18,
  parameter int LEN_W = 17
) (
  input  logic [BUF_W-1:0] buf_left,
  input  logic [LEN_W-1:0] region_left,
  output logic [LEN_W-1:0] chunk
);
  localparam int CW = (BUF_W > LEN_W) ? BUF_W : LEN_W;
  logic [CW-1:0] a, b;

  always_comb begin
    a     = CW'(buf_left);
    b     = CW'(region_left);
    chunk = LEN_W'((a < b) ? a : b);
  end
endmodule

// File: rtl/prd_walk_guard.sv
module prd_walk_guard #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 17,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [ADDR_W-1:0] fetch_ptr,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  region_left,
  input  logic              last_seen,
  output logic              region_empty,
  output logic              walk_over
);
  logic [ADDR_W-1:0] walked;

  assign walked       = fetch_ptr - base;
  assign region_empty = (region_left == '0);
  assign walk_over    = last_seen || (walked >= ADDR_W'(PAGE_BYTES));
endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
  import prd_dma_pkg::*;
#(
  parameter int BUF_W      = 18,
  parameter int PAGE_BYTES = 4096
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  restart,
  input  logic                  dir_to_mem,
  input  logic [PRD_ADDR_W-1:0] tbl_base,
  input  logic [BUF_W-1:0]      buf_size,
  output logic                  desc_rd_valid,
  output logic [PRD_ADDR_W-1:0] desc_rd_addr,
  input  logic                  desc_rd_ready,
  input  logic [63:0]           desc_rd_data,
  output logic                  xfer_valid,
  output logic                  xfer_write,
  output logic [PRD_ADDR_W-1:0] xfer_addr,
  output logic [PRD_LEN_W-1:0]  xfer_len,
  output logic [BUF_W-1:0]      xfer_buf_idx,
  input  logic                  xfer_ready,
  output logic                  busy,
  output logic                  done,
  output logic                  res_buf_done,
  output logic                  res_tbl_end
);
  walk_state_t           state;
  logic [PRD_ADDR_W-1:0] base_q, fetch_ptr;
  region_t               cur;
  logic [BUF_W-1:0]      size_q, idx_q, buf_left;
  logic                  write_q;

  region_t               fetched;
  logic [PRD_LEN_W-1:0]  chunk;
  logic                  region_empty, walk_over;

  assign buf_left = size_q - idx_q;

  prd_desc_decode u_decode (
    .raw    (desc_rd_data),
    .region (fetched)
  );

  prd_chunk_sizer #(.BUF_W(BUF_W), .LEN_W(PRD_LEN_W)) u_sizer (
    .buf_left    (buf_left),
    .region_left (cur.len),
    .chunk       (chunk)
  );

  prd_walk_guard #(.ADDR_W(PRD_ADDR_W), .LEN_W(PRD_LEN_W),
                   .PAGE_BYTES(PAGE_BYTES)) u_guard (
    .fetch_ptr    (fetch_ptr),
    .base         (base_q),
    .region_left  (cur.len),
    .last_seen    (cur.last),
    .region_empty (region_empty),
    .walk_over    (walk_over)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      base_q       <= '0;
      fetch_ptr    <= '0;
      cur          <= '0;
      size_q       <= '0;
      idx_q        <= '0;
      write_q      <= 1'b0;
      done         <= 1'b0;
      res_buf_done <= 1'b0;
      res_tbl_end  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (restart) begin
            base_q    <= tbl_base;
            fetch_ptr <= tbl_base;
          end
          if (start) begin
            state        <= ST_CHECK;
            cur          <= '0;
            size_q       <= buf_size;
            idx_q        <= '0;
            write_q      <= dir_to_mem;
            res_buf_done <= 1'b0;
            res_tbl_end  <= 1'b0;
          end
        end
        ST_CHECK: begin
          if (buf_left == '0) begin
            state        <= ST_IDLE;
            done         <= 1'b1;
            res_buf_done <= 1'b1;
          end else if (region_empty) begin
            if (walk_over) begin
              state       <= ST_IDLE;
              done        <= 1'b1;
              res_tbl_end <= 1'b1;
            end else begin
              state <= ST_FETCH;
            end
          end else begin
            state <= ST_MOVE;
          end
        end
        ST_FETCH: begin
          if (desc_rd_ready) begin
            cur       <= fetched;
            fetch_ptr <= fetch_ptr + PRD_ADDR_W'(PRD_BYTES);
            state     <= ST_CHECK;
          end
        end
        ST_MOVE: begin
          if (xfer_ready) begin
            cur.addr <= cur.addr + PRD_ADDR_W'(chunk);
            cur.len  <= cur.len - chunk;
            idx_q    <= idx_q + BUF_W'(chunk);
            state    <= ST_CHECK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state != ST_IDLE);
  assign desc_rd_valid = (state == ST_FETCH);
  assign desc_rd_addr  = fetch_ptr;
  assign xfer_valid    = (state == ST_MOVE);
  assign xfer_write    = write_q;
  assign xfer_addr     = cur.addr;
  assign xfer_len      = chunk;
  assign xfer_buf_idx  = idx_q;
endmodule

// File: rtl/prd_dma_engine_chk.sv
module prd_dma_engine_chk #(
  parameter int BUF_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              desc_rd_valid,
  input logic [31:0]       desc_rd_addr,
  input logic              desc_rd_ready,
  input logic              xfer_valid,
  input logic [31:0]       xfer_addr,
  input logic [16:0]       xfer_len,
  input logic [BUF_W-1:0]  xfer_buf_idx,
  input logic              xfer_ready,
  input logic              busy,
  input logic              done,
  input logic              res_buf_done,
  input logic              res_tbl_end
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && !res_buf_done && !res_tbl_end));

  assert_desc_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (desc_rd_valid && !desc_rd_ready) |=> (desc_rd_valid && $stable(desc_rd_addr)));

  assert_xfer_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_ready) |=>
      (xfer_valid && $stable(xfer_addr) && $stable(xfer_len)));

  assert_chunk_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> (xfer_len != '0));

  assert_idx_advance_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && xfer_ready) |=>
      (xfer_buf_idx == $past(xfer_buf_idx) + BUF_W'($past(xfer_len))));

  assert_one_result_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({res_buf_done, res_tbl_end}));

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && (res_buf_done || res_tbl_end)));
endmodule

bind prd_dma_engine prd_dma_engine_chk #(.BUF_W(BUF_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .desc_rd_valid (desc_rd_valid),
  .desc_rd_addr  (desc_rd_addr),
  .desc_rd_ready (desc_rd_ready),
  .xfer_valid    (xfer_valid),
  .xfer_addr     (xfer_addr),
  .xfer_len      (xfer_len),
  .xfer_buf_idx  (xfer_buf_idx),
  .xfer_ready    (xfer_ready),
  .busy          (busy),
  .done          (done),
  .res_buf_done  (res_buf_done),
  .res_tbl_end   (res_tbl_end)
);

// File: tb/prd_dma_engine_tb.sv
module prd_dma_engine_tb;
  localparam int BUF_W = 18;
  localparam int NDESC = 520;
  localparam int NLOG  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0, restart = 1'b0, dir_to_mem = 1'b0;
  logic [31:0]       tbl_base = '0;
  logic [BUF_W-1:0]  buf_size = '0;
  logic              desc_rd_valid, desc_rd_ready = 1'b0;
  logic [31:0]       desc_rd_addr;
  logic [63:0]       desc_rd_data = '0;
  logic              xfer_valid, xfer_write, xfer_ready = 1'b0;
  logic [31:0]       xfer_addr;
  logic [16:0]       xfer_len;
  logic [BUF_W-1:0]  xfer_buf_idx;
  logic              busy, done, res_buf_done, res_tbl_end;

  always #10 clk = ~clk;

  prd_dma_engine #(.BUF_W(BUF_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .restart(restart),
    .dir_to_mem(dir_to_mem), .tbl_base(tbl_base), .buf_size(buf_size),
    .desc_rd_valid(desc_rd_valid), .desc_rd_addr(desc_rd_addr),
    .desc_rd_ready(desc_rd_ready), .desc_rd_data(desc_rd_data),
    .xfer_valid(xfer_valid), .xfer_write(xfer_write), .xfer_addr(xfer_addr),
    .xfer_len(xfer_len), .xfer_buf_idx(xfer_buf_idx), .xfer_ready(xfer_ready),
    .busy(busy), .done(done), .res_buf_done(res_buf_done),
    .res_tbl_end(res_tbl_end)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  logic [63:0] tbl [NDESC];
  bit          stall_en = 0;
  bit          tog = 0;

  int          fetch_cnt, chunk_cnt, hold_bad;
  longint      bytes_sum;
  logic [31:0] first_fetch, last_fetch;
  logic [31:0] ch_addr [NLOG];
  logic [16:0] ch_len  [NLOG];
  logic [BUF_W-1:0] ch_idx [NLOG];
  logic        ch_wr   [NLOG];
  logic [31:0] prev_daddr, prev_xaddr;
  bit          prev_dwait, prev_xwait;

  function automatic logic [63:0] mkdesc(logic [31:0] a, logic [15:0] l, logic lst);
    return {lst, 15'h7abc, l, a};   // upper flag bits are noise
  endfunction

  // memory responders, driven at the falling edge
  always @(negedge clk) begin
    int di;
    tog <= ~tog;
    if (desc_rd_valid) begin
      if (prev_dwait && desc_rd_addr != prev_daddr) hold_bad++;
      if (!stall_en || tog) begin
        di = int'((desc_rd_addr - tbl_base) >> 3);
        desc_rd_data  <= (di >= 0 && di < NDESC) ? tbl[di] : 64'h0;
        desc_rd_ready <= 1'b1;
        if (fetch_cnt == 0) first_fetch = desc_rd_addr;
        last_fetch = desc_rd_addr;
        fetch_cnt++;
        prev_dwait = 0;
      end else begin
        desc_rd_ready <= 1'b0;
        prev_dwait = 1; prev_daddr = desc_rd_addr;
      end
    end else begin
      desc_rd_ready <= 1'b0;
      prev_dwait = 0;
    end
    if (xfer_valid) begin
      if (prev_xwait && xfer_addr != prev_xaddr) hold_bad++;
      if (!stall_en || tog) begin
        if (chunk_cnt < NLOG) begin
          ch_addr[chunk_cnt] = xfer_addr; ch_len[chunk_cnt] = xfer_len;
          ch_idx[chunk_cnt] = xfer_buf_idx; ch_wr[chunk_cnt] = xfer_write;
        end
        chunk_cnt++;
        bytes_sum += longint'(xfer_len);
        xfer_ready <= 1'b1;
        prev_xwait = 0;
      end else begin
        xfer_ready <= 1'b0;
        prev_xwait = 1; prev_xaddr = xfer_addr;
      end
    end else begin
      xfer_ready <= 1'b0;
      prev_xwait = 0;
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_tbl();
    for (int i = 0; i < NDESC; i++) tbl[i] = 64'h0;
  endtask

  task automatic run_walk(logic [BUF_W-1:0] n, bit dir, bit rs);
    fetch_cnt = 0; chunk_cnt = 0; bytes_sum = 0; hold_bad = 0;
    @(negedge clk);
    start = 1'b1; restart = rs; buf_size = n; dir_to_mem = dir;
    @(negedge clk);
    start = 1'b0; restart = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
    chk(!res_buf_done && !res_tbl_end, "R1 flags", {res_buf_done, res_tbl_end}, 0);
    chk(!desc_rd_valid && !xfer_valid, "R1 requests", {desc_rd_valid, xfer_valid}, 0);
    chk(desc_rd_addr == 0, "R1 fetch pointer", desc_rd_addr, 0);
  endtask

  task automatic t_single();
    clear_tbl(); tbl_base = 32'h0000_2000;
    tbl[0] = mkdesc(32'h1000_0000, 16'h0101, 1'b1);  // odd -> 0x100
    run_walk(100, 1'b1, 1'b1);
    chk(fetch_cnt == 1 && first_fetch == 32'h2000, "R4 first fetch at base", first_fetch, 32'h2000);
    chk(chunk_cnt == 1 && ch_addr[0] == 32'h1000_0000, "R2 region address", ch_addr[0], 32'h1000_0000);
    chk(ch_len[0] == 100, "R5 chunk limited by buffer", ch_len[0], 100);
    chk(ch_wr[0] == 1'b1, "R10 write direction", ch_wr[0], 1);
    chk(res_buf_done && !res_tbl_end, "R8 buffer done", {res_buf_done, res_tbl_end}, 2);
    @(negedge clk);
    chk(!done && res_buf_done, "R12 pulse then hold", {done, res_buf_done}, 1);
  endtask

  task automatic t_two_stall();
    clear_tbl(); tbl_base = 32'h0000_3000;
    tbl[0] = mkdesc(32'h2000_0000, 16'd61, 1'b0);    // 61 -> 60
    tbl[1] = mkdesc(32'h3000_0000, 16'd60, 1'b1);
    stall_en = 1;
    run_walk(100, 1'b0, 1'b1);
    stall_en = 0;
    chk(fetch_cnt == 2 && last_fetch == 32'h3008, "R4 fetch advance by 8", last_fetch, 32'h3008);
    chk(chunk_cnt == 2 && ch_len[0] == 60 && ch_len[1] == 40, "R5 chunk sizes",
        {ch_len[0], ch_len[1]}, {17'd60, 17'd40});
    chk(ch_addr[1] == 32'h3000_0000 && ch_idx[1] == 60, "R5 second chunk index", ch_idx[1], 60);
    chk(ch_wr[0] == 1'b0, "R10 read direction", ch_wr[0], 0);
    chk(hold_bad == 0, "R11 stable under stall", hold_bad, 0);
    chk(res_buf_done, "R8 result after stalls", res_buf_done, 1);
  endtask

  task automatic t_tbl_short();
    clear_tbl(); tbl_base = 32'h0000_4000;
    tbl[0] = mkdesc(32'h4000_0010, 16'd40, 1'b1);
    tbl[1] = mkdesc(32'h5000_0000, 16'd40, 1'b1);
    run_walk(100, 1'b1, 1'b1);
    chk(fetch_cnt == 1 && chunk_cnt == 1 && ch_len[0] == 40, "R6 stop at final flag",
        fetch_cnt, 1);
    chk(res_tbl_end && !res_buf_done, "R6 table ended", {res_buf_done, res_tbl_end}, 1);
  endtask

  task automatic t_big_region();
    clear_tbl(); tbl_base = 32'h0000_5000;
    tbl[0] = mkdesc(32'h6000_0000, 16'h0000, 1'b0);
    tbl[1] = mkdesc(32'h7000_0000, 16'h0001, 1'b1);
    run_walk(70000, 1'b1, 1'b1);
    chk(chunk_cnt == 2 && ch_len[0] == 17'h10000, "R3 zero length is 64K", ch_len[0], 17'h10000);
    chk(ch_len[1] == 17'd4464 && ch_idx[1] == 18'h10000, "R3 odd one forced to 64K",
        ch_len[1], 4464);
    chk(res_buf_done, "R8 buffer done after 64K", res_buf_done, 1);
  endtask

  task automatic t_guard();
    clear_tbl(); tbl_base = 32'h0001_0000;
    for (int i = 0; i < NDESC; i++) tbl[i] = mkdesc(32'h8000_0000 + 32'(i * 16), 16'd2, 1'b0);
    run_walk(2000, 1'b1, 1'b1);
    chk(fetch_cnt == 512, "R7 fetch count at page guard", fetch_cnt, 512);
    chk(last_fetch == 32'h0001_0FF8, "R7 last fetch address", last_fetch, 32'h0001_0FF8);
    chk(bytes_sum == 1024, "R7 bytes moved", bytes_sum, 1024);
    chk(res_tbl_end, "R7 table ended", res_tbl_end, 1);
  endtask

  task automatic t_zero_buf();
    clear_tbl(); tbl[0] = mkdesc(32'h9000_0000, 16'd8, 1'b1);
    run_walk(0, 1'b0, 1'b1);
    chk(fetch_cnt == 0 && chunk_cnt == 0, "R8 zero buffer no fetch", fetch_cnt, 0);
    chk(res_buf_done && !res_tbl_end, "R8 zero buffer result", res_buf_done, 1);
  endtask

  task automatic t_restart();
    clear_tbl(); tbl_base = 32'h0000_6000;
    tbl[0] = mkdesc(32'hA000_0000, 16'd10, 1'b1);
    tbl[1] = mkdesc(32'hB000_0000, 16'd20, 1'b1);
    tbl[2] = mkdesc(32'hC000_0000, 16'd30, 1'b1);
    run_walk(10, 1'b0, 1'b1);
    chk(first_fetch == 32'h6000 && ch_addr[0] == 32'hA000_0000, "R4 restart loads base",
        first_fetch, 32'h6000);
    run_walk(5, 1'b0, 1'b0);
    chk(first_fetch == 32'h6008 && ch_addr[0] == 32'hB000_0000, "R9 start keeps fetch pointer",
        first_fetch, 32'h6008);
    run_walk(5, 1'b0, 1'b0);
    chk(fetch_cnt == 1 && ch_addr[0] == 32'hC000_0000, "R9 start drops leftover region",
        ch_addr[0], 32'hC000_0000);
    run_walk(4, 1'b0, 1'b1);
    chk(first_fetch == 32'h6000, "R4 second restart", first_fetch, 32'h6000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_two_stall();
    t_tbl_short();
    t_big_region();
    t_guard();
    t_zero_buf();
    t_restart();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule